// File: doc/BRIEF.md
# Operand Staging Register Unit

This block is the operand and result staging stage of a small integer datapath. Operands reach it by push operations rather than as instruction fields. Each push moves the current first source register into the second source register and loads a new value into the first. The value comes from one of the general registers or from a sign-extended constant carried on the push data input. A separate integer operation then combines the staged operands and writes the result register. A result-store operation copies that register back into the general register file.

Each accepted strobe carries exactly one decoded operation. Every register affected by that operation changes on the same rising clock edge. Floating-point operation codes are recognised but not executed. They leave all state alone and raise a one-cycle unimplemented flag. Other units read the general register file through an independent read port.

Top module: `opstage_unit`

## Requirements
- R1: An active-low asynchronous reset clears both source registers, the result register, every general register and the unimplemented flag to zero.
- R2: A push operation copies the old first source register into the second source register and loads the pushed value into the first, both on the accepted edge.
- R3: Code 9 pushes push_data_i[7:0] and code 10 pushes push_data_i[15:0], each sign-extended to the full width. Code 11 pushes push_data_i unchanged.
- R4: Code 8 pushes the general register selected by idx_i.
- R5: Code 1 writes second plus first source into the result, code 3 writes their bitwise AND and code 4 writes their bitwise OR.
- R6: Code 2 writes second source minus first source, so the operand pushed earlier is the minuend.
- R7: Code 5 copies the first source to the result, code 6 writes its one's complement and code 7 its two's complement. The second source is not read.
- R8: Code 12 copies the result register into the general register selected by idx_i, which rd_data_o then shows for rd_idx_i.
- R9: Codes 13 to 31, the floating-point codes 13 to 17 and the unassigned codes above them, change no register and set unimpl_o high for exactly the cycle after the accepting edge.
- R10: While valid_i is low, no register changes, whatever op_i, idx_i and push_data_i carry.
- R11: Codes 1 to 7 leave both source registers unchanged, so the same operands can be combined again.
- R12: Code 0 is a no-operation that changes no register and does not set unimpl_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe, one operation per high cycle |
| op_i | input | 5 | Decoded operation code |
| idx_i | input | 4 | General register index for codes 8 and 12 |
| push_data_i | input | 32 | Constant for push codes 9 to 11 |
| rd_idx_i | input | 4 | Read port index into the general register file |
| rd_data_o | output | 32 | General register selected by rd_idx_i |
| result_o | output | 32 | Result register |
| unimpl_o | output | 1 | One-cycle unimplemented-operation pulse |

## Verification
The bench builds the unit with its default values, a 32-bit data width and 16 general registers. With these values the sign positions at bits 7, 15 and 31 can be checked on both sides of each boundary. The lowest and highest register indices are reached through both the store path and the read port. Operand order is probed with non-commutative data, and the two's complement of the most negative value is covered. The floating-point and unassigned codes are interleaved with real work, which shows that the staged operands are still intact afterwards.

// File: rtl/opstage_pkg.sv
package opstage_pkg;
  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OP_NOP   = 5'd0;
  localparam logic [OP_W-1:0] OP_ADD   = 5'd1;
  localparam logic [OP_W-1:0] OP_SUB   = 5'd2;
  localparam logic [OP_W-1:0] OP_AND   = 5'd3;
  localparam logic [OP_W-1:0] OP_OR    = 5'd4;
  localparam logic [OP_W-1:0] OP_MOV   = 5'd5;
  localparam logic [OP_W-1:0] OP_NOT   = 5'd6;
  localparam logic [OP_W-1:0] OP_NEG   = 5'd7;
  localparam logic [OP_W-1:0] OP_PREG  = 5'd8;
  localparam logic [OP_W-1:0] OP_PB    = 5'd9;
  localparam logic [OP_W-1:0] OP_PW    = 5'd10;
  localparam logic [OP_W-1:0] OP_PL    = 5'd11;
  localparam logic [OP_W-1:0] OP_STORE = 5'd12;
  localparam logic [OP_W-1:0] OP_FIRST_FP = 5'd13;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_MOV, ALU_NOT, ALU_NEG
  } alu_e;

  typedef enum logic [1:0] {
    PS_REG, PS_B, PS_W, PS_L
  } psel_e;

  typedef struct packed {
    logic  push_en;
    psel_e push_sel;
    logic  alu_en;
    alu_e  alu_op;
    logic  store_en;
    logic  unimpl;
  } ctl_t;
endpackage

// File: rtl/opstage_dec.sv
module opstage_dec
  import opstage_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output ctl_t            ctl_o
);
  always_comb begin
    ctl_o          = '0;
    ctl_o.push_sel = PS_L;
    ctl_o.alu_op   = ALU_MOV;
    if (valid_i) begin
      case (op_i)
        OP_NOP:   ;
        OP_ADD:   begin ctl_o.alu_en = 1'b1; ctl_o.alu_op = ALU_ADD; end
        OP_SUB:   begin ctl_o.alu_en = 1'b1; ctl_o.alu_op = ALU_SUB; end
        OP_AND:   begin ctl_o.alu_en = 1'b1; ctl_o.alu_op = ALU_AND; end
        OP_OR:    begin ctl_o.alu_en = 1'b1; ctl_o.alu_op = ALU_OR;  end
        OP_MOV:   begin ctl_o.alu_en = 1'b1; ctl_o.alu_op = ALU_MOV; end
        OP_NOT:   begin ctl_o.alu_en = 1'b1; ctl_o.alu_op = ALU_NOT; end
        OP_NEG:   begin ctl_o.alu_en = 1'b1; ctl_o.alu_op = ALU_NEG; end
        OP_PREG:  begin ctl_o.push_en = 1'b1; ctl_o.push_sel = PS_REG; end
        OP_PB:    begin ctl_o.push_en = 1'b1; ctl_o.push_sel = PS_B; end
        OP_PW:    begin ctl_o.push_en = 1'b1; ctl_o.push_sel = PS_W; end
        OP_PL:    begin ctl_o.push_en = 1'b1; ctl_o.push_sel = PS_L; end
        OP_STORE: ctl_o.store_en = 1'b1;
        default:  ctl_o.unimpl = 1'b1;   // fp and unassigned codes
      endcase
    end
  end
endmodule

// File: rtl/opstage_alu.sv
module opstage_alu
  import opstage_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_e              op_i,
  input  logic [DATA_W-1:0] a_i,   // first source
  input  logic [DATA_W-1:0] b_i,   // second source
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = b_i + a_i;
      ALU_SUB: y_o = b_i - a_i;
      ALU_AND: y_o = b_i & a_i;
      ALU_OR:  y_o = b_i | a_i;
      ALU_MOV: y_o = a_i;
      ALU_NOT: y_o = ~a_i;
      ALU_NEG: y_o = '0 - a_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/opstage_gpr.sv
module opstage_gpr #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic [DATA_W-1:0] rb_data_o
);
  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     regs_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))            regs_q[g] <= wdata_i;
    end
  end

  assign ra_data_o = regs_q[ra_idx_i];
  assign rb_data_o = regs_q[rb_idx_i];
endmodule

// File: rtl/opstage_unit.sv
module opstage_unit
  import opstage_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] result_o,
  output logic              unimpl_o
);
  ctl_t              ctl;
  logic [DATA_W-1:0] src1_q, src2_q, res_q;
  logic [DATA_W-1:0] gpr_val, push_val, alu_y;
  logic              unimpl_q;

  opstage_dec u_dec (
    .valid_i (valid_i),
    .op_i    (op_i),
    .ctl_o   (ctl)
  );

  opstage_gpr #(.DATA_W(DATA_W), .NREG(NREG)) u_gpr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctl.store_en),
    .widx_i    (idx_i),
    .wdata_i   (res_q),
    .ra_idx_i  (idx_i),
    .ra_data_o (gpr_val),
    .rb_idx_i  (rd_idx_i),
    .rb_data_o (rd_data_o)
  );

  opstage_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (ctl.alu_op),
    .a_i  (src1_q),
    .b_i  (src2_q),
    .y_o  (alu_y)
  );

  always_comb begin
    unique case (ctl.push_sel)
      PS_REG:  push_val = gpr_val;
      PS_B:    push_val = {{(DATA_W-8){push_data_i[7]}}, push_data_i[7:0]};
      PS_W:    push_val = {{(DATA_W-16){push_data_i[15]}}, push_data_i[15:0]};
      default: push_val = push_data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src1_q   <= '0;
      src2_q   <= '0;
      res_q    <= '0;
      unimpl_q <= 1'b0;
    end else begin
      if (ctl.push_en) begin
        src2_q <= src1_q;
        src1_q <= push_val;
      end
      if (ctl.alu_en) res_q <= alu_y;
      unimpl_q <= ctl.unimpl;
    end
  end

  assign result_o = res_q;
  assign unimpl_o = unimpl_q;
endmodule

// File: rtl/opstage_chk.sv
module opstage_chk
  import opstage_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              unimpl_o,
  input logic [DATA_W-1:0] src1_q,
  input logic [DATA_W-1:0] src2_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && src1_q == '0 && src2_q == '0 && !unimpl_o));

  // R2
  push_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= OP_PREG && op_i <= OP_PL) |=> src2_q == $past(src1_q));

  // R6
  sub_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SUB) |=> result_o == $past(src2_q) - $past(src1_q));

  // R9
  unimpl_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= OP_FIRST_FP) |=> unimpl_o);

  // R9
  unimpl_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i >= OP_FIRST_FP) |=> !unimpl_o);

  // R9
  unimpl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= OP_FIRST_FP) |=>
      ($stable(result_o) && $stable(src1_q) && $stable(src2_q)));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(src1_q) && $stable(src2_q)));

  // R11
  alu_keep_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= OP_ADD && op_i <= OP_NEG) |=>
      ($stable(src1_q) && $stable(src2_q)));
endmodule

bind opstage_unit opstage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .result_o (result_o),
  .unimpl_o (unimpl_o),
  .src1_q   (src1_q),
  .src2_q   (src2_q)
);

// File: tb/sim_opstage_unit.sv
`timescale 1ns/1ps
module sim_opstage_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [3:0]  idx_i = '0;
  logic [31:0] push_data_i = '0;
  logic [3:0]  rd_idx_i = '0;
  logic [31:0] rd_data_o, result_o;
  logic        unimpl_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  opstage_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .idx_i(idx_i), .push_data_i(push_data_i), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o), .result_o(result_o), .unimpl_o(unimpl_o)
  );

  // {op, idx, data, expected result, expected unimpl}
  localparam int NV = 30;
  localparam logic [73:0] VEC [NV] = '{
    {5'd11, 4'd0, 32'h0000_0005, 32'h0000_0000, 1'b0},  // R2 push 5
    {5'd11, 4'd0, 32'h0000_0003, 32'h0000_0000, 1'b0},  // R2 push 3
    {5'd1,  4'd0, 32'h0,         32'h0000_0008, 1'b0},  // R5 add
    {5'd2,  4'd0, 32'h0,         32'h0000_0002, 1'b0},  // R6 5-3
    {5'd3,  4'd0, 32'h0,         32'h0000_0001, 1'b0},  // R5 and
    {5'd4,  4'd0, 32'h0,         32'h0000_0007, 1'b0},  // R5 or
    {5'd5,  4'd0, 32'h0,         32'h0000_0003, 1'b0},  // R7 mov
    {5'd6,  4'd0, 32'h0,         32'hFFFF_FFFC, 1'b0},  // R7 not
    {5'd7,  4'd0, 32'h0,         32'hFFFF_FFFD, 1'b0},  // R7 neg
    {5'd1,  4'd0, 32'h0,         32'h0000_0008, 1'b0},  // R11 operands kept
    {5'd12, 4'd4, 32'h0,         32'h0000_0008, 1'b0},  // R8 store r4
    {5'd9,  4'd0, 32'h0000_00F0, 32'h0000_0008, 1'b0},  // R3 byte neg
    {5'd5,  4'd0, 32'h0,         32'hFFFF_FFF0, 1'b0},  // R3
    {5'd10, 4'd0, 32'h1234_8001, 32'hFFFF_FFF0, 1'b0},  // R3 word neg
    {5'd5,  4'd0, 32'h0,         32'hFFFF_8001, 1'b0},  // R3
    {5'd2,  4'd0, 32'h0,         32'h0000_7FEF, 1'b0},  // R6 order
    {5'd9,  4'd0, 32'hFFFF_FF7F, 32'h0000_7FEF, 1'b0},  // R3 byte pos
    {5'd5,  4'd0, 32'h0,         32'h0000_007F, 1'b0},  // R3
    {5'd10, 4'd0, 32'h0000_7FFF, 32'h0000_007F, 1'b0},  // R3 word pos
    {5'd5,  4'd0, 32'h0,         32'h0000_7FFF, 1'b0},  // R3
    {5'd8,  4'd4, 32'hDEAD_BEEF, 32'h0000_7FFF, 1'b0},  // R4 push r4
    {5'd2,  4'd0, 32'h0,         32'h0000_7FF7, 1'b0},  // R4 7FFF-8
    {5'd8,  4'd0, 32'h0,         32'h0000_7FF7, 1'b0},  // R4 push r0
    {5'd1,  4'd0, 32'h0,         32'h0000_0008, 1'b0},  // R4 0+8
    {5'd13, 4'd0, 32'h0,         32'h0000_0008, 1'b1},  // R9 fp add
    {5'd16, 4'd0, 32'h0,         32'h0000_0008, 1'b1},  // R9 fp div
    {5'd5,  4'd0, 32'h0,         32'h0000_0000, 1'b0},  // R9 src1 intact
    {5'd25, 4'd0, 32'h0,         32'h0000_0000, 1'b1},  // R9 unassigned
    {5'd11, 4'd0, 32'h8000_0000, 32'h0000_0000, 1'b0},  // R2
    {5'd7,  4'd0, 32'h0,         32'h8000_0000, 1'b0}   // R7 neg min
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(logic [4:0] op, logic [3:0] idx, logic [31:0] d);
    @(negedge clk_i);
    op_i = op; idx_i = idx; push_data_i = d; valid_i = 1'b1;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1", result_o, 32'h0);
    chk("R1", {31'h0, unimpl_o}, 32'h0);
    for (int i = 0; i < 16; i++) begin
      rd_idx_i = 4'(i); #1;
      chk("R1", rd_data_o, 32'h0);
    end
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][73:69], VEC[i][68:65], VEC[i][64:33]);
      chk($sformatf("R2-table entry %0d result", i), result_o, VEC[i][32:1]);
      chk($sformatf("R9-table entry %0d flag", i), {31'h0, unimpl_o}, {31'h0, VEC[i][0]});
    end

    // R8 read port sees stored value in r4 only
    for (int i = 0; i < 16; i++) begin
      rd_idx_i = 4'(i); #1;
      chk("R8", rd_data_o, (i == 4) ? 32'h8 : 32'h0);
    end
    do_op(5'd12, 4'd15, 32'h0);  // R8 top index
    rd_idx_i = 4'd15; #1;
    chk("R8", rd_data_o, 32'h8000_0000);

    // R9 flag drops after one cycle
    do_op(5'd17, 4'd0, 32'h0);
    chk("R9", {31'h0, unimpl_o}, 32'h1);
    @(posedge clk_i); #1;
    chk("R9", {31'h0, unimpl_o}, 32'h0);

    // R10 idle strobe ignores inputs
    @(negedge clk_i);
    op_i = 5'd11; push_data_i = 32'h1; idx_i = 4'd0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    op_i = 5'd12; idx_i = 4'd15;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R10", result_o, 32'h8000_0000);
    chk("R10", rd_data_o, 32'h8000_0000);
    do_op(5'd5, 4'd0, 32'h0);
    chk("R10", result_o, 32'h8000_0000);

    // R12 no-operation
    do_op(5'd0, 4'd0, 32'h5);
    chk("R12", result_o, 32'h8000_0000);
    chk("R12", {31'h0, unimpl_o}, 32'h0);
    do_op(5'd2, 4'd0, 32'h0);  // 0 - 80000000, src pair untouched by NOP
    chk("R12", result_o, 32'h8000_0000);

    // R1 asynchronous reset mid-run
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    chk("R1", result_o, 32'h0);
    chk("R1", rd_data_o, 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    do_op(5'd11, 4'd0, 32'h9);
    do_op(5'd2, 4'd0, 32'h0);  // 0 - 9: second source was cleared
    chk("R1", result_o, 32'hFFFF_FFF7);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule